// File: doc/BRIEF.md
# One-Shot Target Time Alarm

This block watches a running timestamp, made of a seconds count and a nanoseconds count, and raises an alarm once that timestamp reaches a target that software has programmed. Software writes the target seconds and target nanoseconds, then arms the alarm. The first cycle in which the alarm is armed and the timestamp is at or past the target produces a one-cycle event pulse. The same cycle latches a sticky hit flag and drops the arm bit. No further event follows until software arms the alarm again.

The seconds field is the more significant part of the comparison. Matching uses greater-than-or-equal rather than equality. An increment of several nanoseconds that steps over the exact target therefore still fires. The hit flag drives an interrupt line through a separate mask bit. Software clears the flag by writing 1 to it.

Top module: `time_alarm`

## Requirements
- R1: After reset, event_o, armed_o, sts_o and irq_o are 0, both target words are 0 and the interrupt mask is 0.
- R2: While armed_o is 0, no event pulse is produced and sts_o is not set, whatever the timestamp.
- R3: When armed_o is 1 and the timestamp sampled at a clock edge is at or past the target, event_o is 1 for the cycle after that edge.
- R4: The timestamp and the target are compared as unsigned values {seconds, nanoseconds}, with seconds most significant. A larger nanoseconds count with fewer seconds does not fire. A timestamp that jumps past the target fires.
- R5: The edge that fires also clears armed_o, so a timestamp that stays past the target gives no further events.
- R6: The edge that fires sets sts_o. sts_o then holds until a write to address 3 with data bit 0 set. A write there with bit 0 clear has no effect.
- R7: irq_o is 1 exactly when sts_o is 1 and the interrupt mask (bit 1 of the control word at address 2) is 1.
- R8: A control write with data bit 0 set, made at the same edge as a firing, keeps armed_o at 1. If the timestamp is still past the target, this gives a second event on the following cycle.
- R9: A status-clear write made at the same edge as a firing leaves sts_o at 1.
- R10: A control write at address 2 with bit 0 clear disarms the alarm, and a later timestamp past the target then produces no event.
- R11: Writes with wr_en at 1 go by wr_addr: 0 loads the target seconds, 1 loads the target nanoseconds, 2 loads the control word (bit 0 arm, bit 1 interrupt mask) and 3 is the status clear. A new target takes effect from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | DATA_W | Write data |
| time_sec | input | SEC_W | Running timestamp, seconds |
| time_ns | input | NS_W | Running timestamp, nanoseconds |
| event_o | output | 1 | One-cycle alarm event |
| armed_o | output | 1 | Alarm currently armed |
| sts_o | output | 1 | Sticky hit flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bound checker checks these on every cycle: an event needs the alarm to have been armed and the timestamp to have reached the target on the previous edge, an armed alarm with a due timestamp always fires, the alarm disarms itself unless a same-edge re-arm write is present, and the hit flag stays set until it is cleared and wins over a clear at the same edge. The directed scenarios show the behaviours that depend on a sequence of stimulus. These are the register map in use, the seconds-versus-nanoseconds ordering with a skipped target, the fact that a status write with bit 0 clear has no effect, masking of the interrupt, and the exact cycles of the double event when a re-arm write races a firing.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
   typedef enum logic [1:0] {
      A_TGT_SEC = 2'd0,
      A_TGT_NS  = 2'd1,
      A_CTRL    = 2'd2,
      A_STS     = 2'd3
   } alarm_addr_e;

   localparam int unsigned CTRL_ARM_BIT = 0;
   localparam int unsigned CTRL_IRQ_BIT = 1;
   localparam int unsigned STS_HIT_BIT  = 0;

   typedef struct packed {
      logic ctrl_wr;
      logic arm_val;
      logic sts_clr;
   } alarm_cmd_t;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
   import alarm_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SEC_W  = 32,
   parameter int unsigned NS_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SEC_W-1:0]  tgt_sec,
   output logic [NS_W-1:0]   tgt_ns,
   output logic              irq_en,
   output alarm_cmd_t        cmd
);
   logic sel_sec, sel_ns, sel_ctrl, sel_sts;

   always_comb begin
      sel_sec  = wr_en && (wr_addr == A_TGT_SEC);
      sel_ns   = wr_en && (wr_addr == A_TGT_NS);
      sel_ctrl = wr_en && (wr_addr == A_CTRL);
      sel_sts  = wr_en && (wr_addr == A_STS);
      cmd.ctrl_wr = sel_ctrl;
      cmd.arm_val = wr_data[CTRL_ARM_BIT];
      cmd.sts_clr = sel_sts && wr_data[STS_HIT_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_sec <= '0;
         tgt_ns  <= '0;
         irq_en  <= 1'b0;
      end else begin
         if (sel_sec)  tgt_sec <= wr_data[SEC_W-1:0];
         if (sel_ns)   tgt_ns  <= wr_data[NS_W-1:0];
         if (sel_ctrl) irq_en  <= wr_data[CTRL_IRQ_BIT];
      end
   end
endmodule

// File: rtl/alarm_ge_cmp.sv
module alarm_ge_cmp #(
   parameter int unsigned SEC_W = 32,
   parameter int unsigned NS_W  = 32,
   parameter bit          SPLIT = 1'b1
) (
   input  logic [SEC_W-1:0] now_sec,
   input  logic [NS_W-1:0]  now_ns,
   input  logic [SEC_W-1:0] tgt_sec,
   input  logic [NS_W-1:0]  tgt_ns,
   output logic             reached
);
   generate
      if (SPLIT) begin : g_split
         logic sec_gt, sec_eq, ns_ge;
         always_comb begin
            sec_gt  = now_sec > tgt_sec;
            sec_eq  = now_sec == tgt_sec;
            ns_ge   = now_ns >= tgt_ns;
            reached = sec_gt || (sec_eq && ns_ge);
         end
      end else begin : g_flat
         always_comb reached = {now_sec, now_ns} >= {tgt_sec, tgt_ns};
      end
   endgenerate
endmodule

// File: rtl/alarm_fire.sv
module alarm_fire
   import alarm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reached,
   input  alarm_cmd_t cmd,
   output logic       armed,
   output logic       hit,
   output logic       pulse
);
   logic fire;

   always_comb fire = armed && reached;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         hit   <= 1'b0;
         pulse <= 1'b0;
      end else begin
         pulse <= fire;
         // a software write to the control word wins over the self-clear
         if (cmd.ctrl_wr)  armed <= cmd.arm_val;
         else if (fire)    armed <= 1'b0;
         // setting beats clearing in the same cycle
         if (fire)         hit <= 1'b1;
         else if (cmd.sts_clr) hit <= 1'b0;
      end
   end
endmodule

// File: rtl/time_alarm.sv
module time_alarm
   import alarm_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned SEC_W     = 32,
   parameter int unsigned NS_W      = 32,
   parameter bit          CMP_SPLIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEC_W-1:0]  time_sec,
   input  logic [NS_W-1:0]   time_ns,
   output logic              event_o,
   output logic              armed_o,
   output logic              sts_o,
   output logic              irq_o
);
   generate
      if (SEC_W > DATA_W) begin : g_bad_sec
         $error("time_alarm: SEC_W must not exceed DATA_W");
      end
      if (NS_W > DATA_W) begin : g_bad_ns
         $error("time_alarm: NS_W must not exceed DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("time_alarm: DATA_W must hold the control bits");
      end
   endgenerate

   logic [SEC_W-1:0] tgt_sec;
   logic [NS_W-1:0]  tgt_ns;
   logic             irq_en;
   logic             reached;
   alarm_cmd_t       cmd;

   alarm_regs #(.DATA_W(DATA_W), .SEC_W(SEC_W), .NS_W(NS_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .tgt_sec (tgt_sec),
      .tgt_ns  (tgt_ns),
      .irq_en  (irq_en),
      .cmd     (cmd)
   );

   alarm_ge_cmp #(.SEC_W(SEC_W), .NS_W(NS_W), .SPLIT(CMP_SPLIT)) u_cmp (
      .now_sec (time_sec),
      .now_ns  (time_ns),
      .tgt_sec (tgt_sec),
      .tgt_ns  (tgt_ns),
      .reached (reached)
   );

   alarm_fire u_fire (
      .clk     (clk),
      .rst_n   (rst_n),
      .reached (reached),
      .cmd     (cmd),
      .armed   (armed_o),
      .hit     (sts_o),
      .pulse   (event_o)
   );

   always_comb irq_o = sts_o && irq_en;
endmodule

// File: rtl/alarm_chk.sv
module alarm_chk
   import alarm_pkg::*;
#(
   parameter int unsigned SEC_W = 32,
   parameter int unsigned NS_W  = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic             wr_bit0,
   input logic [SEC_W-1:0] time_sec,
   input logic [NS_W-1:0]  time_ns,
   input logic [SEC_W-1:0] tgt_sec,
   input logic [NS_W-1:0]  tgt_ns,
   input logic             event_o,
   input logic             armed_o,
   input logic             sts_o,
   input logic             irq_o
);
   logic rearm_wr, clr_wr, due;
   always_comb begin
      rearm_wr = wr_en && (wr_addr == A_CTRL) && wr_bit0;
      clr_wr   = wr_en && (wr_addr == A_STS) && wr_bit0;
      due      = {time_sec, time_ns} >= {tgt_sec, tgt_ns};
   end

   a_r3_event_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |-> $past(armed_o));
   a_r3_due_fires: assert property (@(posedge clk) disable iff (!rst_n)
      armed_o && due |=> event_o);
   a_r4_event_needs_reach: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |-> $past(due));
   a_r5_self_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      event_o && !$past(rearm_wr) |-> !armed_o);
   a_r6_event_sets_sts: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |-> sts_o);
   a_r6_sts_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      sts_o && !clr_wr |=> sts_o);
   a_r7_irq_needs_sts: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> sts_o);
   a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      armed_o && due && clr_wr |=> sts_o);
endmodule

bind time_alarm alarm_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_bit0  (wr_data[0]),
   .time_sec (time_sec),
   .time_ns  (time_ns),
   .tgt_sec  (tgt_sec),
   .tgt_ns   (tgt_ns),
   .event_o  (event_o),
   .armed_o  (armed_o),
   .sts_o    (sts_o),
   .irq_o    (irq_o)
);

// File: tb/time_alarm_bench.sv
module time_alarm_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] tsec = '0;
   logic [31:0] tns = '0;
   logic        event_o, armed_o, sts_o, irq_o;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   time_alarm u_time_alarm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .time_sec(tsec), .time_ns(tns),
      .event_o(event_o), .armed_o(armed_o), .sts_o(sts_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // starts and ends at a falling edge
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic t_reset;
      chk("R1 event", {31'd0, event_o}, 32'd0);
      chk("R1 armed", {31'd0, armed_o}, 32'd0);
      chk("R1 sts",   {31'd0, sts_o},   32'd0);
      chk("R1 irq",   {31'd0, irq_o},   32'd0);
   endtask

   task automatic t_unarmed;
      tsec = 32'd5; tns = 32'd7;   // past the reset target of zero
      repeat (3) begin
         @(negedge clk);
         chk("R2 no event unarmed", {31'd0, event_o}, 32'd0);
      end
      chk("R2 sts unset", {31'd0, sts_o}, 32'd0);
   endtask

   task automatic t_basic;
      tsec = 32'd10; tns = 32'd400;
      wr(2'd0, 32'd10);
      wr(2'd1, 32'd500);
      wr(2'd2, 32'd1);              // R11: arm, mask off
      chk("R11 armed after ctrl write", {31'd0, armed_o}, 32'd1);
      @(negedge clk);
      chk("R3 below target", {31'd0, event_o}, 32'd0);
      tns = 32'd500;
      @(negedge clk);
      chk("R3 event at target", {31'd0, event_o}, 32'd1);
      chk("R5 disarmed", {31'd0, armed_o}, 32'd0);
      chk("R6 sts set", {31'd0, sts_o}, 32'd1);
      chk("R7 irq masked", {31'd0, irq_o}, 32'd0);
      @(negedge clk);
      chk("R3 single cycle", {31'd0, event_o}, 32'd0);
      repeat (3) begin
         @(negedge clk);
         chk("R5 no repeat", {31'd0, event_o}, 32'd0);
      end
   endtask

   task automatic t_irq_sts;
      wr(2'd2, 32'd2);              // mask on, not armed
      chk("R7 irq on", {31'd0, irq_o}, 32'd1);
      wr(2'd3, 32'd0);
      chk("R6 write 0 ignored", {31'd0, sts_o}, 32'd1);
      wr(2'd3, 32'd1);
      chk("R6 cleared", {31'd0, sts_o}, 32'd0);
      chk("R7 irq off", {31'd0, irq_o}, 32'd0);
   endtask

   task automatic t_skip;
      tsec = 32'd19; tns = 32'd999_999_999;
      wr(2'd0, 32'd20);
      wr(2'd1, 32'd999_999_990);
      wr(2'd2, 32'd1);
      @(negedge clk);
      chk("R4 bigger ns fewer sec", {31'd0, event_o}, 32'd0);
      tsec = 32'd20; tns = 32'd0;
      @(negedge clk);
      chk("R4 same sec lower ns", {31'd0, event_o}, 32'd0);
      tns = 32'd999_999_985;
      @(negedge clk);
      chk("R4 just below", {31'd0, event_o}, 32'd0);
      tsec = 32'd21; tns = 32'd5;
      @(negedge clk);
      chk("R4 skipped target fires", {31'd0, event_o}, 32'd1);
      wr(2'd3, 32'd1);
   endtask

   task automatic t_disarm;
      tsec = 32'd1; tns = 32'd0;
      wr(2'd0, 32'd2);
      wr(2'd1, 32'd0);
      wr(2'd2, 32'd1);
      wr(2'd2, 32'd0);
      chk("R10 disarmed", {31'd0, armed_o}, 32'd0);
      tsec = 32'd3;
      repeat (2) begin
         @(negedge clk);
         chk("R10 no event", {31'd0, event_o}, 32'd0);
      end
      chk("R10 sts unset", {31'd0, sts_o}, 32'd0);
   endtask

   task automatic t_rearm_race;
      tsec = 32'd1;
      wr(2'd2, 32'd1);              // target 2 s, time 1 s
      tsec = 32'd2;
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'd1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      chk("R8 event", {31'd0, event_o}, 32'd1);
      chk("R8 stays armed", {31'd0, armed_o}, 32'd1);
      @(negedge clk);
      chk("R8 second event", {31'd0, event_o}, 32'd1);
      chk("R8 then disarmed", {31'd0, armed_o}, 32'd0);
      @(negedge clk);
      chk("R8 quiet", {31'd0, event_o}, 32'd0);
   endtask

   task automatic t_clear_race;
      tsec = 32'd1;
      wr(2'd2, 32'd1);
      chk("R9 sts before", {31'd0, sts_o}, 32'd1);
      tsec = 32'd2;
      wr(2'd3, 32'd1);              // clear at the firing edge
      chk("R9 event", {31'd0, event_o}, 32'd1);
      chk("R9 set wins", {31'd0, sts_o}, 32'd1);
      wr(2'd3, 32'd1);
      chk("R9 clear later", {31'd0, sts_o}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unarmed();
      t_basic();
      t_irq_sts();
      t_skip();
      t_disarm();
      t_rearm_race();
      t_clear_race();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule